// File: doc/BRIEF.md
# Serial Control-Register Slave

This block is the control port of a clock fan-out device. It listens on a two-wire serial bus (SMBus-style clock and data lines), answers at one fixed device address and holds six 8-bit control registers. A bus master can write or read one register at a time, or move a run of consecutive registers in one block transfer. The registers drive six output-enable bits, an amplitude override select with its 3-bit amplitude code, a read-only revision/vendor identification byte, and the byte-count value that a block read reports first.

Both bus lines are oversampled by the system clock through a synchronizer. Start and stop conditions, and the rising and falling SCL edges, are detected from the synchronized samples. The slave pulls SDA low through an open-drain enable (`sda_oe` = 1 means drive low). It changes that enable only after it has detected a falling SCL edge. The command byte that follows the write address selects the access. Bit 7 set means a single-register access. Bit 7 clear means a block access. Bits 6:0 give the first register index.

Top module: `smbslv_top`

## Requirements
- R1: After reset the registers read 0x00, 0x15, 0xE0, 0x08, 0x06, 0xD8 at indices 0 to 5, so `out_en` = 0x3F, `amp_sel` = 1, `amp_code` = 5, `rev_code` = 0, `vendor_id` = 8, `byte_count` = 6 and `sda_oe` = 0.
- R2: Only the address byte 0xD6 (write) or 0xD7 (read) is acknowledged. After any other address the slave leaves SDA released until the next start, and the bytes that follow change nothing.
- R3: Command bit 7 = 1 selects a single-register access and bit 7 = 0 selects a block access. In both cases bits 6:0 are the starting index.
- R4: Output enable k comes from register 1 bit 4, bit 2 and bit 0 for k = 0, 1, 2, and from register 2 bit 7, bit 6 and bit 5 for k = 3, 4, 5. A byte write updates these bits and nothing else changes them.
- R5: A byte read (write address, command, repeated start, read address) returns the indexed register, sent MSB first.
- R6: A block write takes a count byte and then writes that many data bytes to ascending indices. Every one of these bytes is acknowledged. Data bytes beyond the count are not acknowledged and are discarded.
- R7: A block read returns the byte-count register (index 4) first, then the registers from the command index upward, until the master answers with a NACK.
- R8: Indices 6 to 127 are acknowledged, but writes to them are discarded and reads of them return 0x00.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A stop releases SDA and ends the transfer, and a partly received byte is not written. A start at any point restarts address reception.
- R11: Register 3 is read-only: `rev_code` = bits 7:4 and `vendor_id` = bits 3:0.
- R12: `amp_sel` is register 5 bit 7 and `amp_code` is register 5 bits 6:4.
- R13: `byte_count` mirrors register 4, which can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_en | output | 6 | Per-output enable bits |
| amp_sel | output | 1 | 1 selects the programmed amplitude |
| amp_code | output | 3 | Programmed amplitude code |
| rev_code | output | 4 | Revision identification |
| vendor_id | output | 4 | Vendor identification |
| byte_count | output | 8 | Byte-count register value |

## Verification
A corrupted index pointer or byte-kind state shows up on the wire within the next transferred byte. The read data comes back from the wrong register, or an acknowledge is missing or extra on a byte the master can observe. A wrong remaining-count value shows as an ACK or NACK in the wrong place during a block write, and a register beyond the count changes. A bad shift or bit counter garbles the first byte a read returns. A drive-enable error appears as SDA moving while SCL is high, which a bench monitor catches in the same clock cycle.

// File: rtl/smbslv_pkg.sv
// Shared constants, state types and register-map helpers for the serial
// control-register slave. Assumes a fixed six-byte map.
package smbslv_pkg;

    localparam int NUM_REGS  = 6;
    localparam int NUM_OUTS  = 6;
    localparam int IDX_W     = 7;   // index field width inside the command byte
    localparam int RIDX_W    = $clog2(NUM_REGS);
    localparam int ID_IDX    = 3;
    localparam int CNT_IDX   = 4;
    localparam int AMP_IDX   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } rx_kind_t;

    // Power-up contents of each register.
    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            1:       return 8'h15;
            2:       return 8'hE0;
            3:       return 8'h08;
            4:       return 8'h06;
            5:       return 8'hD8;
            default: return 8'h00;
        endcase
    endfunction

    // Register holding the enable bit of output k.
    function automatic int oe_reg(input int k);
        return (k < 3) ? 1 : 2;
    endfunction

    // Bit position of the enable bit of output k.
    function automatic int oe_bit(input int k);
        case (k)
            0:       return 4;
            1:       return 2;
            2:       return 0;
            3:       return 7;
            4:       return 6;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/smbslv_line_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain
// and detects SCL edges and start/stop conditions.
// Assumes each bus phase lasts several system clocks.
module smbslv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_level = scl_pipe[STAGES-1];
    assign sda_level = sda_pipe[STAGES-1];

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_level && !scl_prev;
        scl_fall  = !scl_level && scl_prev;
        start_det = scl_level && scl_prev && sda_prev && !sda_level;
        stop_det  = scl_level && scl_prev && !sda_prev && sda_level;
    end

endmodule

// File: rtl/smbslv_regfile.sv
// Six-byte control register file with a write port, an indexed read port
// and the decoded control outputs. The identification byte is read-only.
module smbslv_regfile
    import smbslv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [7:0]          rd_data,
    output logic [NUM_OUTS-1:0] out_en,
    output logic                amp_sel,
    output logic [2:0]          amp_code,
    output logic [3:0]          rev_code,
    output logic [3:0]          vendor_id,
    output logic [7:0]          byte_count
);

    localparam logic [IDX_W-1:0] REG_LIMIT = IDX_W'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    // Register storage: reset to power-up values, write when addressed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs[i] <= reset_value(i);
            end else if (wr_en && wr_idx == IDX_W'(i) && i != ID_IDX) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Indexed read: indices past the map read as zero.
    always_comb begin
        rd_data = '0;
        if (rd_idx < REG_LIMIT) begin
            rd_data = regs[rd_idx[RIDX_W-1:0]];
        end
    end

    // Output enable bits taken from their scattered map positions.
    for (genvar g = 0; g < NUM_OUTS; g++) begin : g_oe
        assign out_en[g] = regs[oe_reg(g)][oe_bit(g)];
    end

    assign amp_sel    = regs[AMP_IDX][7];
    assign amp_code   = regs[AMP_IDX][6:4];
    assign rev_code   = regs[ID_IDX][7:4];
    assign vendor_id  = regs[ID_IDX][3:0];
    assign byte_count = regs[CNT_IDX];

    p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < REG_LIMIT));

    p_id_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(ID_IDX)) |=> $stable({rev_code, vendor_id}));

    p_quiet_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(out_en));

endmodule

// File: rtl/smbslv_engine.sv
// Bus protocol engine: receives the address, command, count and data bytes,
// acknowledges them, and shifts out read data. It moves the SDA drive only
// after a detected SCL fall. Assumes synchronized inputs from the line sync.
module smbslv_engine
    import smbslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_level,
    input  logic             sda_level,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_value,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    localparam logic [IDX_W-1:0] REG_LIMIT = IDX_W'(NUM_REGS);

    bus_state_t       state;
    rx_kind_t         kind;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sreg;
    logic [7:0]       tx_byte;
    logic [7:0]       remaining;
    logic [IDX_W-1:0] ptr;
    logic             byte_mode;
    logic             rw_read;
    logic             first_tx;
    logic             master_ack;

    logic             byte_done;
    logic             addr_hit;
    logic             cnt_first;
    logic [7:0]       next_tx;

    // Decode of the current byte and of the next byte to transmit.
    always_comb begin
        byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
        addr_hit  = (rx_sreg[7:1] == DEV_ADDR);
        cnt_first = first_tx && !byte_mode;
        next_tx   = cnt_first ? cnt_value : rd_data;
    end

    assign rd_idx  = ptr;
    assign wr_idx  = ptr;
    assign wr_data = rx_sreg;
    assign wr_en   = byte_done && (kind == K_DATA) && (remaining != 8'd0)
                     && (ptr < REG_LIMIT);

    // Protocol sequencing, shift registers and open-drain drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= K_ADDR;
            bitcnt     <= '0;
            rx_sreg    <= '0;
            tx_byte    <= '0;
            remaining  <= '0;
            ptr        <= '0;
            byte_mode  <= 1'b0;
            rw_read    <= 1'b0;
            first_tx   <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sreg <= {rx_sreg[6:0], sda_level};
                        bitcnt  <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        state  <= ST_RX_ACK;
                        case (kind)
                            K_ADDR: begin
                                if (addr_hit) begin
                                    sda_oe   <= 1'b1;
                                    rw_read  <= rx_sreg[0];
                                    first_tx <= 1'b1;
                                    kind     <= K_CMD;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            K_CMD: begin
                                sda_oe    <= 1'b1;
                                byte_mode <= rx_sreg[7];
                                ptr       <= rx_sreg[6:0];
                                remaining <= 8'd1;
                                kind      <= rx_sreg[7] ? K_DATA : K_CNT;
                            end
                            K_CNT: begin
                                sda_oe    <= 1'b1;
                                remaining <= rx_sreg;
                                kind      <= K_DATA;
                            end
                            default: begin
                                if (remaining != 8'd0) begin
                                    sda_oe    <= 1'b1;
                                    ptr       <= ptr + 1'b1;
                                    remaining <= remaining - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw_read) begin
                            state    <= ST_TX;
                            tx_byte  <= next_tx;
                            sda_oe   <= ~next_tx[7];
                            first_tx <= 1'b0;
                            if (!cnt_first) begin
                                ptr <= ptr + 1'b1;
                            end
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            tx_byte <= {tx_byte[6:0], 1'b0};
                            sda_oe  <= ~tx_byte[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        master_ack <= !sda_level;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            state    <= ST_TX;
                            bitcnt   <= '0;
                            tx_byte  <= next_tx;
                            sda_oe   <= ~next_tx[7];
                            first_tx <= 1'b0;
                            if (!cnt_first) begin
                                ptr <= ptr + 1'b1;
                            end
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_level);

    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_foreign_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && kind == K_ADDR && !addr_hit) |=> (state == ST_IDLE && !sda_oe));

    p_write_only_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_RX && kind == K_DATA));

endmodule

// File: rtl/smbslv_top.sv
// Top of the serial control-register slave: line synchronizer, protocol
// engine and register file. Assumes SDA is wired open-drain outside.
module smbslv_top
    import smbslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6B,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [5:0] out_en,
    output logic       amp_sel,
    output logic [2:0] amp_code,
    output logic [3:0] rev_code,
    output logic [3:0] vendor_id,
    output logic [7:0] byte_count
);

    logic             scl_level;
    logic             sda_level;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    smbslv_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_level (scl_level),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbslv_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_level (scl_level),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .cnt_value (byte_count),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    smbslv_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .out_en     (out_en),
        .amp_sel    (amp_sel),
        .amp_code   (amp_code),
        .rev_code   (rev_code),
        .vendor_id  (vendor_id),
        .byte_count (byte_count)
    );

endmodule

// File: tb/smbslv_top_test.sv
// Bench: a bus master model, a vector table of byte writes and read-backs,
// then directed block, address, abort and reset checks.
module smbslv_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 190000;
    localparam int NVEC       = 12;

    // {index, write data, expected read-back, expected out_en}
    localparam logic [31:0] VECS [NVEC] = '{
        32'h01_00_00_38, 32'h01_10_10_39, 32'h01_04_04_3A, 32'h01_01_01_3C,
        32'h02_00_00_04, 32'h02_80_80_0C, 32'h02_40_40_14, 32'h02_20_20_24,
        32'h01_15_15_27, 32'h02_E0_E0_3F, 32'h03_FF_08_3F, 32'h09_55_00_3F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [5:0] out_en;
    logic       amp_sel;
    logic [2:0] amp_code;
    logic [3:0] rev_code;
    logic [3:0] vendor_id;
    logic [7:0] byte_count;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    logic prev_oe = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbslv_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .out_en     (out_en),
        .amp_sel    (amp_sel),
        .amp_code   (amp_code),
        .rev_code   (rev_code),
        .vendor_id  (vendor_id),
        .byte_count (byte_count)
    );

    // R9 monitor: the drive must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl) r9_viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        b = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(input logic ack_it, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!ack_it);
    endtask

    task automatic byte_write(input logic [7:0] idx, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h80 | idx, a1); wr_byte(d, a2);
        bus_stop;
        ok = a0 & a1 & a2;
    endtask

    task automatic byte_read(input logic [7:0] idx, output logic [7:0] v, output logic ok);
        logic a0, a1, a2;
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h80 | idx, a1);
        bus_start;
        wr_byte(8'hD7, a2); rd_byte(1'b0, v);
        bus_stop;
        ok = a0 & a1 & a2;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       ok, a0, a1, a2, a3;
        logic [7:0] v, v0, v1, v2, v3;
        logic [7:0] rst_vals [6];
        rst_vals = '{8'h00, 8'h15, 8'hE0, 8'h08, 8'h06, 8'hD8};

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state at the ports
        chk("R1 out_en", out_en, 6'h3F);
        chk("R1 amp_sel", amp_sel, 1'b1);
        chk("R1 amp_code", amp_code, 3'd5);
        chk("R1 rev_code", rev_code, 4'd0);
        chk("R11 vendor_id", vendor_id, 4'd8);
        chk("R13 byte_count", byte_count, 8'h06);
        chk("R1 sda_oe", sda_oe, 1'b0);

        // R1, R5: every reset value read back through byte reads
        for (int i = 0; i < 6; i++) begin
            byte_read(8'(i), v, ok);
            chk("R5 byte read acks", ok, 1'b1);
            chk("R1 reset value", v, rst_vals[i]);
        end

        // R3, R4, R8, R11: vector table of byte writes and read-backs
        for (int i = 0; i < NVEC; i++) begin
            byte_write(VECS[i][31:24], VECS[i][23:16], ok);
            chk("R8 byte write acks", ok, 1'b1);
            chk("R4 out_en after write", out_en, VECS[i][5:0]);
            byte_read(VECS[i][31:24], v, ok);
            chk("R5 read-back", v, VECS[i][15:8]);
        end
        chk("R11 id unchanged", {rev_code, vendor_id}, 8'h08);

        // R12: amplitude fields
        byte_write(8'd5, 8'h30, ok);
        chk("R12 amp_sel low", amp_sel, 1'b0);
        chk("R12 amp_code 3", amp_code, 3'd3);
        byte_write(8'd5, 8'hF0, ok);
        chk("R12 amp_sel high", amp_sel, 1'b1);
        chk("R12 amp_code 7", amp_code, 3'd7);

        // R13: writable count register
        byte_write(8'd4, 8'h03, ok);
        chk("R13 byte_count written", byte_count, 8'h03);

        // R7, R3: block read from index 0
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h00, a1);
        bus_start;
        wr_byte(8'hD7, a2);
        rd_byte(1'b1, v0); rd_byte(1'b1, v1); rd_byte(1'b1, v2); rd_byte(1'b0, v3);
        bus_stop;
        chk("R7 block read acks", {a0, a1, a2}, 3'b111);
        chk("R7 count first", v0, 8'h03);
        chk("R7 reg0", v1, 8'h00);
        chk("R7 reg1", v2, 8'h15);
        chk("R7 reg2", v3, 8'hE0);
        chk("R7 released after nack", sda_oe, 1'b0);

        // R8: block read past the map
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h06, a1);
        bus_start;
        wr_byte(8'hD7, a2);
        rd_byte(1'b1, v0); rd_byte(1'b0, v1);
        bus_stop;
        chk("R8 oor block acks", {a0, a1, a2}, 3'b111);
        chk("R8 oor count first", v0, 8'h03);
        chk("R8 oor data zero", v1, 8'h00);

        // R6: block write of two bytes, third byte beyond count
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h00, a1); wr_byte(8'h02, a2);
        wr_byte(8'h11, a3);
        chk("R6 header and first data ack", {a0, a1, a2, a3}, 4'b1111);
        wr_byte(8'h22, a0); wr_byte(8'h33, a1);
        bus_stop;
        chk("R6 second data ack", a0, 1'b1);
        chk("R6 beyond count nack", a1, 1'b0);
        byte_read(8'd0, v, ok);
        chk("R6 reg0", v, 8'h11);
        byte_read(8'd1, v, ok);
        chk("R6 reg1", v, 8'h22);
        byte_read(8'd2, v, ok);
        chk("R6 reg2 untouched", v, 8'hE0);
        chk("R6 out_en", out_en, 6'h38);

        // R2: foreign write address
        bus_start;
        wr_byte(8'hA0, a0); wr_byte(8'h81, a1); wr_byte(8'h3F, a2);
        bus_stop;
        chk("R2 foreign addr nack", {a0, a1, a2}, 3'b000);
        chk("R2 out_en unchanged", out_en, 6'h38);
        // R2: foreign read address
        bus_start;
        wr_byte(8'hD5, a0);
        rd_byte(1'b0, v);
        bus_stop;
        chk("R2 foreign read nack", a0, 1'b0);
        chk("R2 line released", v, 8'hFF);

        // R10: stop in the middle of a data byte
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h85, a1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop;
        chk("R10 released on stop", sda_oe, 1'b0);
        chk("R10 partial byte dropped", {amp_sel, amp_code}, 4'b1111);
        // R10: repeated start aborts and restarts address reception
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h85, a1);
        bus_start;
        wr_byte(8'hD6, a0); wr_byte(8'h85, a1); wr_byte(8'h48, a2);
        bus_stop;
        chk("R10 restart acks", {a0, a1, a2}, 3'b111);
        chk("R10 restart write", {amp_sel, amp_code}, 4'b0100);

        // R9: drive moved only while SCL low
        chk("R9 sda change with scl high", r9_viol, 0);

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R1 out_en after reset", out_en, 6'h3F);
        chk("R1 amp after reset", {amp_sel, amp_code}, 4'b1101);
        chk("R13 count after reset", byte_count, 8'h06);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule